// File: doc/BRIEF.md
# Stereo Audio Serial Receiver with Fixed-MSB Word Alignment

This block receives the data side of a stereo audio serial link. An external bit clock, a channel-select line and a serial data line enter the system clock domain through two-flop synchronisers. On every rising bit-clock edge the block samples one data bit and the channel-select level. It assembles each channel slot into a word of the configured receive width, placing the first bit of the slot at the MSB.

A change of channel-select closes the current word. The word is written into a small receive FIFO with a tag that names its channel. The link may use either of two framings, picked by `fmt_msbj`. In the standard framing, the MSB follows the channel-select change by one bit period. In the MSB-justified framing, the MSB comes in the same bit period as the change. The sender's word length does not matter. Bits beyond the receive width are dropped, and a short word is zero-filled at its low end.

While the FIFO holds data, the block raises a DMA service request. The consumer pops the head word with `rd_en`. A word that completes while the FIFO is full is lost, and a sticky overrun flag records the loss. The system clock must run at least four times faster than the bit clock. `fmt_msbj` may only change while the block is in reset.

Top module: `audio_rx`

## Requirements
- R1: Data and channel-select are taken only at the rising edge of `bclk_in`. Changes of `sdata_in` while `bclk_in` is high have no effect on the received words.
- R2: With `fmt_msbj`=0, the bit sampled at the first rising edge that shows a new channel-select level is the LSB-side last bit of the previous word. The next bit is the MSB of the new word.
- R3: With `fmt_msbj`=1, the bit sampled at the first rising edge that shows a new channel-select level is the MSB of the new word.
- R4: When a slot carries more bits than WORD_W, only the first WORD_W bits are kept, and the rest are ignored.
- R5: When a slot carries fewer bits than WORD_W, the received bits fill the word from the MSB down, and the missing low bits read as zero.
- R6: Each stored word carries `rd_chan` equal to the channel-select level of its slot (0 = left, 1 = right). Left and right slots may differ in length.
- R7: After reset, no word is stored for the slot in progress before the first channel-select change the block observes.
- R8: `dma_req` is high exactly while the FIFO is non-empty. Words leave in arrival order, one per cycle with `rd_en` high. `rd_data`/`rd_chan` show the oldest word.
- R9: A word completing while the FIFO holds DEPTH words is discarded without changing the FIFO contents. `overrun` then goes high and stays high until reset.
- R10: After reset, `dma_req` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | External serial bit clock (asynchronous) |
| lrsel_in | input | 1 | Channel-select line: 0 left, 1 right |
| sdata_in | input | 1 | Serial data, MSB first |
| fmt_msbj | input | 1 | 0 = one-bit-delayed framing, 1 = MSB-justified framing |
| rd_en | input | 1 | Pop the head word of the FIFO |
| rd_data | output | WORD_W | Head word of the FIFO |
| rd_chan | output | 1 | Channel tag of the head word |
| dma_req | output | 1 | Service request: FIFO non-empty |
| overrun | output | 1 | Sticky flag: a word was lost to a full FIFO |

## Verification
The assertions check on every cycle that the FIFO fill level stays bounded and the bit counter never passes the word width. They also check that the head word holds still when no pop occurs, that a push raises the request, and that the overrun flag only rises after a word met a full FIFO, never falls, and leaves the write pointer unmoved. Bit alignment in both framings, truncation and zero-fill, channel tagging with unequal slots, the skipped first slot and immunity to data changes during the high phase of the bit clock can only be shown by the bench. The bench sweeps sender word lengths below, at and above the receive width in both framings and compares every popped word against the expected value it computes.

// File: rtl/audio_rx.sv
module audio_rx #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_in,
  input  logic              lrsel_in,
  input  logic              sdata_in,
  input  logic              fmt_msbj,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_chan,
  output logic              dma_req,
  output logic              overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] NMAX = CW'(WORD_W);
  localparam logic [AW:0]   FMAX = (AW+1)'(DEPTH);

  logic [2:0] bclk_q;
  logic [1:0] lr_q, sd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= '0;
      lr_q   <= '0;
      sd_q   <= '0;
    end else begin
      bclk_q <= {bclk_q[1:0], bclk_in};
      lr_q   <= {lr_q[0], lrsel_in};
      sd_q   <= {sd_q[0], sdata_in};
    end
  end

  wire rise = bclk_q[1] & ~bclk_q[2];
  wire lr   = lr_q[1];
  wire din  = sd_q[1];

  logic              lr_last, seen, armed;
  logic [WORD_W-1:0] shreg, sh_acc;
  logic [CW-1:0]     nbits;

  wire chg   = rise & seen & (lr != lr_last);
  wire store = chg & armed;

  always_comb begin
    sh_acc = shreg;
    if (nbits < NMAX) sh_acc[WORD_W-1-int'(nbits)] = din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_last <= 1'b0;
      seen    <= 1'b0;
      armed   <= 1'b0;
      shreg   <= '0;
      nbits   <= '0;
    end else if (rise) begin
      lr_last <= lr;
      seen    <= 1'b1;
      if (chg) begin
        armed <= 1'b1;
        if (fmt_msbj) begin
          shreg <= {din, {(WORD_W-1){1'b0}}};
          nbits <= CW'(1);
        end else begin
          shreg <= '0;
          nbits <= '0;
        end
      end else begin
        shreg <= sh_acc;
        if (nbits < NMAX) nbits <= nbits + CW'(1);
      end
    end
  end

  logic [WORD_W:0] mem [DEPTH];
  logic [AW:0]     wptr, rptr;
  wire  [AW:0]     fill  = wptr - rptr;
  wire             full  = (fill == FMAX);
  wire             empty = (fill == '0);
  wire             push  = store & ~full;
  wire             pop   = rd_en & ~empty;
  wire [WORD_W:0]  wr_entry = {lr_last, fmt_msbj ? shreg : sh_acc};

  always_ff @(posedge clk) begin
    if (push) mem[wptr[AW-1:0]] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      if (store & full) overrun <= 1'b1;
    end
  end

  assign rd_data = mem[rptr[AW-1:0]][WORD_W-1:0];
  assign rd_chan = mem[rptr[AW-1:0]][WORD_W];
  assign dma_req = ~empty;

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) fill <= FMAX); // R9
  AST_NBITS_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) nbits <= NMAX); // R4
  AST_OVR_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R9
  AST_OVR_CAUSE:    assert property (@(posedge clk) disable iff (!rst_n) $rose(overrun) |-> $past(store && full)); // R9
  AST_DROP_FULL:    assert property (@(posedge clk) disable iff (!rst_n) (store && full && !rd_en) |=> $stable(wptr)); // R9
  AST_PUSH_REQ:     assert property (@(posedge clk) disable iff (!rst_n) push |=> dma_req); // R8
  AST_HEAD_STABLE:  assert property (@(posedge clk) disable iff (!rst_n) (!empty && !rd_en) |=> $stable({rd_chan, rd_data})); // R8
endmodule

// File: tb/audio_rx_bench.sv
module audio_rx_bench;
  localparam int W = 8;
  localparam int D = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, lrsel = 1'b1, sd = 1'b0, fmt = 1'b0, rd_en = 1'b0;
  logic [W-1:0] rd_data;
  logic rd_chan, dma_req, overrun;
  logic dly = 1'b0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  audio_rx #(.WORD_W(W), .DEPTH(D)) u_audio_rx (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .lrsel_in(lrsel), .sdata_in(sd),
    .fmt_msbj(fmt), .rd_en(rd_en), .rd_data(rd_data), .rd_chan(rd_chan),
    .dma_req(dma_req), .overrun(overrun));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic f);
    @(negedge clk);
    rst_n = 1'b0; fmt = f; bclk = 1'b0; lrsel = 1'b1; sd = 1'b0; rd_en = 1'b0; dly = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one bit period: data set while bclk low, disturbed while bclk high (R1)
  task automatic sbit(input logic lr, input logic d);
    logic v;
    if (fmt) v = d; else begin v = dly; dly = d; end
    @(negedge clk);
    bclk = 1'b0; lrsel = lr; sd = v;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (2) @(negedge clk);
    sd = ~v;
    repeat (2) @(negedge clk);
  endtask

  task automatic slot(input logic lr, input int len, input int slen, input logic [15:0] v);
    for (int i = 0; i < slen; i++) sbit(lr, (i < len) ? v[len-1-i] : 1'b0);
  endtask

  function automatic logic [W-1:0] expw(input int len, input logic [15:0] v);
    int n;
    n = (len < W) ? len : W;
    return W'((v >> (len - n)) << (W - n));
  endfunction

  function automatic logic [15:0] pat(input int k, input int len);
    logic [15:0] m;
    m = 16'((32'd1 << len) - 1);
    return 16'(k * 16'h5B + len * 13 + 16'hA5) & m;
  endfunction

  task automatic pop_check(input logic [W-1:0] ew, input logic ec, input string req);
    chk(dma_req === 1'b1, "R8 request", int'(dma_req), 1);
    chk(rd_data === ew, req, int'(rd_data), int'(ew));
    chk(rd_chan === ec, "R6 channel tag", int'(rd_chan), int'(ec));
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic scenario(input logic f, input int len);
    string req;
    do_reset(f);
    slot(1'b1, 8, 8, 16'hFF);          // partial first slot, never stored (R7)
    for (int k = 0; k < 4; k++)
      slot(k[0], len, len + ((k % 2 == 1) ? 3 : 1), pat(k, len));
    sbit(1'b0, 1'b0);
    sbit(1'b0, 1'b0);
    repeat (8) @(negedge clk);
    req = f ? "R3 msb-justified word" : "R2 delayed-framing word";
    if (len > W) req = {req, " R4 truncation"};
    if (len < W) req = {req, " R5 zero fill"};
    for (int k = 0; k < 4; k++) pop_check(expw(len, pat(k, len)), k[0], req);
    chk(dma_req === 1'b0, "R7 no extra word stored", int'(dma_req), 0);
    chk(overrun === 1'b0, "R9 no overrun", int'(overrun), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    chk(dma_req === 1'b0, "R10 reset request", int'(dma_req), 0);
    chk(overrun === 1'b0, "R10 reset overrun", int'(overrun), 0);

    for (int f = 0; f < 2; f++)
      for (int len = 4; len <= 12; len += 2)
        scenario(f[0], len);

    // R9: six words into a four-entry FIFO
    do_reset(1'b1);
    slot(1'b1, 8, 8, 16'h00);
    for (int k = 0; k < 6; k++) slot(k[0], 8, 9, pat(k, 8));
    sbit(1'b0, 1'b0);
    repeat (8) @(negedge clk);
    chk(overrun === 1'b1, "R9 overrun set", int'(overrun), 1);
    for (int k = 0; k < 4; k++) pop_check(expw(8, pat(k, 8)), k[0], "R9 kept words");
    chk(dma_req === 1'b0, "R9 lost words absent", int'(dma_req), 0);
    chk(overrun === 1'b1, "R9 overrun sticky", int'(overrun), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule